// File: doc/BRIEF.md
# Branch and Loop-Count Resolution Unit

This block is the branch-decision stage of a small 16-bit processor with a 22-bit program counter. It takes one decoded operation per cycle, together with a qualifying valid bit. The operation can be a T-flag conditional branch, an external-condition branch, or a decrement-and-branch on one of two loop counters. For each one the block produces the next program counter, a taken indication and a flush request for the following instruction. For decrement-and-branch it also returns a counter write-back and the updated zero flags.

A taken branch goes to PC + 2 plus the sign-extended displacement, wrapped to 22 bits. Both ordinary and external-condition branches carry a per-instruction delay-slot bit. When that bit is set, the next instruction runs whatever the outcome. When it is clear, the next instruction is flushed only if the branch is taken.

Decrement-and-branch decides from the selected zero flag as it stands before the decrement. That flag is stale on the first iteration, so software must clear or set it before entering a loop. All results are registered and appear one clock after the operation is presented.

Top module: `branch_resolve_unit`

## Requirements
- R1: For `op_i`=00 (flag branch), `br_type_i` selects the condition. 01 is always taken, 10 is taken when `t_flag_i`=0, 11 is taken when `t_flag_i`=1, and 00 is never taken.
- R2: When a branch is taken, `next_pc_o` equals `pc_i` + 2 + the displacement sign-extended to 22 bits, modulo 2^22.
- R3: When a valid operation is not taken, or no operation is valid, `next_pc_o` equals `pc_i` + 1, modulo 2^22.
- R4: For `op_i` 00 and 01, `flush_o` is 1 only when the branch is taken and `dslot_i`=0. With `dslot_i`=1 it stays 0.
- R5: For `op_i`=01 (external branch), the branch is taken when `ext_cond_i[ext_sel_i]`=1. The `br_type_i` field is ignored for this operation.
- R6: For `op_i`=10 (decrement-and-branch), `cnt_sel_i`=0 selects counter `r6_i` and flag `z0_i`, and `cnt_sel_i`=1 selects `r7_i` and `z1_i`. The branch is taken when the selected flag is 1, as sampled before the decrement.
- R7: For decrement-and-branch, `cnt_we_o`=1 and `cnt_sel_o` echoes the selector. `cnt_wdata_o` is the selected counter minus 1, wrapping. The selected flag output becomes 1 exactly when that new value is zero, and the other flag output is passed through unchanged.
- R8: Decrement-and-branch never asserts `flush_o`, taken or not.
- R9: With `valid_i`=0, or with `op_i`=11 (reserved), `taken_o`, `flush_o` and `cnt_we_o` are 0, and `z0_o`/`z1_o` pass through `z0_i`/`z1_i`.
- R10: All outputs are registered and reflect the inputs of the previous rising clock edge. While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | 00 flag branch, 01 external branch, 10 decrement-and-branch, 11 reserved |
| br_type_i | input | 2 | Flag branch condition code |
| dslot_i | input | 1 | Delay-slot bit |
| disp_i | input | DISP_W (10) | Signed branch displacement |
| pc_i | input | PC_W (22) | Address of the branch instruction |
| t_flag_i | input | 1 | T condition flag |
| ext_cond_i | input | NUM_EXT (4) | External condition inputs |
| ext_sel_i | input | EXT_SEL_W (2) | External condition index |
| cnt_sel_i | input | 1 | Loop counter select (0: r6, 1: r7) |
| r6_i | input | CNT_W (16) | Loop counter 0 |
| r7_i | input | CNT_W (16) | Loop counter 1 |
| z0_i | input | 1 | Zero flag paired with r6 |
| z1_i | input | 1 | Zero flag paired with r7 |
| next_pc_o | output | PC_W (22) | Resolved next PC |
| taken_o | output | 1 | Branch taken |
| flush_o | output | 1 | Squash the following instruction |
| cnt_we_o | output | 1 | Counter write enable |
| cnt_sel_o | output | 1 | Counter being written |
| cnt_wdata_o | output | CNT_W (16) | Decremented counter value |
| z0_o | output | 1 | Updated zero flag 0 |
| z1_o | output | 1 | Updated zero flag 1 |

## Verification
Every result is due exactly one clock after the operation is presented, because each output passes through one register stage. The bench drives inputs on the falling edge and keeps the expected values it computes from those inputs in a queue. On the next falling edge, half a period after the capturing rising edge, it pops one entry and compares all outputs against it. Directed cases cover every condition code, the delay-slot combinations, a stale-flag loop entry, counter wrap from zero, a counter reaching zero, and displacement extremes that wrap the PC. Long random sequences then run with no idle gaps between operations.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    OP_FLAG = 2'b00,
    OP_EXT  = 2'b01,
    OP_LOOP = 2'b10,
    OP_RSVD = 2'b11
  } bru_op_e;
endpackage

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
  parameter int PC_W   = 22,
  parameter int DISP_W = 10
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   target_o,
  output logic [PC_W-1:0]   seq_o
);
  localparam int EXT_W = PC_W - DISP_W;
  logic [PC_W-1:0] disp_sx;

  assign disp_sx  = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign target_o = pc_i + PC_W'(2) + disp_sx;
  assign seq_o    = pc_i + PC_W'(1);
endmodule

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
  import bru_pkg::*;
#(
  parameter int NUM_EXT   = 4,
  parameter int EXT_SEL_W = $clog2(NUM_EXT)
) (
  input  bru_op_e              op_i,
  input  logic [1:0]           br_type_i,
  input  logic                 t_flag_i,
  input  logic [NUM_EXT-1:0]   ext_cond_i,
  input  logic [EXT_SEL_W-1:0] ext_sel_i,
  output logic                 cond_o
);
  logic flag_cond;
  logic ext_cond;

  always_comb begin
    unique case (br_type_i)
      2'b01:   flag_cond = 1'b1;
      2'b10:   flag_cond = ~t_flag_i;
      2'b11:   flag_cond = t_flag_i;
      default: flag_cond = 1'b0;
    endcase
  end

  assign ext_cond = ext_cond_i[ext_sel_i];

  always_comb begin
    unique case (op_i)
      OP_FLAG: cond_o = flag_cond;
      OP_EXT:  cond_o = ext_cond;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_loop_ctrl.sv
module bru_loop_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             sel_i,
  input  logic [CNT_W-1:0] r6_i,
  input  logic [CNT_W-1:0] r7_i,
  input  logic             z0_i,
  input  logic             z1_i,
  output logic             take_o,
  output logic [CNT_W-1:0] dec_o,
  output logic             z0_o,
  output logic             z1_o
);
  logic [CNT_W-1:0] cnt_sel;
  logic             dec_zero;

  assign cnt_sel  = sel_i ? r7_i : r6_i;
  // decision uses the flag as it stood before this decrement
  assign take_o   = sel_i ? z1_i : z0_i;
  assign dec_o    = cnt_sel - CNT_W'(1);
  assign dec_zero = (dec_o == '0);
  assign z0_o     = sel_i ? z0_i : dec_zero;
  assign z1_o     = sel_i ? dec_zero : z1_i;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int PC_W      = 22,
  parameter int DISP_W    = 10,
  parameter int CNT_W     = 16,
  parameter int NUM_EXT   = 4,
  parameter int EXT_SEL_W = $clog2(NUM_EXT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [1:0]           br_type_i,
  input  logic                 dslot_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic                 t_flag_i,
  input  logic [NUM_EXT-1:0]   ext_cond_i,
  input  logic [EXT_SEL_W-1:0] ext_sel_i,
  input  logic                 cnt_sel_i,
  input  logic [CNT_W-1:0]     r6_i,
  input  logic [CNT_W-1:0]     r7_i,
  input  logic                 z0_i,
  input  logic                 z1_i,
  output logic [PC_W-1:0]      next_pc_o,
  output logic                 taken_o,
  output logic                 flush_o,
  output logic                 cnt_we_o,
  output logic                 cnt_sel_o,
  output logic [CNT_W-1:0]     cnt_wdata_o,
  output logic                 z0_o,
  output logic                 z1_o
);
  bru_op_e          op;
  logic [PC_W-1:0]  target, seq_pc;
  logic             br_cond;
  logic             loop_take;
  logic [CNT_W-1:0] loop_dec;
  logic             loop_z0, loop_z1;
  logic             is_loop, take_d, flush_d;

  assign op = bru_op_e'(op_i);

  bru_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .target_o (target),
    .seq_o    (seq_pc)
  );

  bru_cond_eval #(.NUM_EXT(NUM_EXT), .EXT_SEL_W(EXT_SEL_W)) u_cond (
    .op_i       (op),
    .br_type_i  (br_type_i),
    .t_flag_i   (t_flag_i),
    .ext_cond_i (ext_cond_i),
    .ext_sel_i  (ext_sel_i),
    .cond_o     (br_cond)
  );

  bru_loop_ctrl #(.CNT_W(CNT_W)) u_loop (
    .sel_i  (cnt_sel_i),
    .r6_i   (r6_i),
    .r7_i   (r7_i),
    .z0_i   (z0_i),
    .z1_i   (z1_i),
    .take_o (loop_take),
    .dec_o  (loop_dec),
    .z0_o   (loop_z0),
    .z1_o   (loop_z1)
  );

  assign is_loop = valid_i && (op == OP_LOOP);
  assign take_d  = valid_i && (is_loop ? loop_take : br_cond);
  // loop op always runs its successor; branches honour the delay-slot bit
  assign flush_d = take_d && !is_loop && !dslot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o   <= '0;
      taken_o     <= 1'b0;
      flush_o     <= 1'b0;
      cnt_we_o    <= 1'b0;
      cnt_sel_o   <= 1'b0;
      cnt_wdata_o <= '0;
      z0_o        <= 1'b0;
      z1_o        <= 1'b0;
    end else begin
      next_pc_o   <= take_d ? target : seq_pc;
      taken_o     <= take_d;
      flush_o     <= flush_d;
      cnt_we_o    <= is_loop;
      cnt_sel_o   <= is_loop && cnt_sel_i;
      cnt_wdata_o <= is_loop ? loop_dec : '0;
      z0_o        <= is_loop ? loop_z0 : z0_i;
      z1_o        <= is_loop ? loop_z1 : z1_i;
    end
  end

  a_r4_flush_implies_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> taken_o);

  a_r4_dslot_keeps_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dslot_i) |=> !flush_o);

  a_r8_loop_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=> (!flush_o && cnt_we_o));

  a_r6_loop_stale_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=> (taken_o == ($past(cnt_sel_i) ? $past(z1_i) : $past(z0_i))));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!taken_o && !flush_o && !cnt_we_o && z0_o == $past(z0_i) && z1_o == $past(z1_i)));

  a_r3_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i || !valid_i) |=> (taken_o || next_pc_o == ($past(pc_i) + PC_W'(1))));

  a_r7_other_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && !cnt_sel_i) |=> (z1_o == $past(z1_i)));
endmodule

// File: tb/branch_resolve_unit_bench.sv
module branch_resolve_unit_bench;
  localparam int PC_W = 22, DISP_W = 10, CNT_W = 16, NUM_EXT = 4, SEL_W = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i, dslot_i, t_flag_i, cnt_sel_i, z0_i, z1_i;
  logic [1:0] op_i, br_type_i;
  logic [DISP_W-1:0] disp_i;
  logic [PC_W-1:0] pc_i;
  logic [NUM_EXT-1:0] ext_cond_i;
  logic [SEL_W-1:0] ext_sel_i;
  logic [CNT_W-1:0] r6_i, r7_i;
  logic [PC_W-1:0] next_pc_o;
  logic taken_o, flush_o, cnt_we_o, cnt_sel_o, z0_o, z1_o;
  logic [CNT_W-1:0] cnt_wdata_o;

  typedef struct {
    logic [PC_W-1:0] pc; logic tk, fl, we, sel; logic [CNT_W-1:0] wd; logic z0, z1; int op;
  } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  branch_resolve_unit u_branch_resolve_unit (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    longint t;
    bit c;
    e.op = valid_i ? int'(op_i) : -1;
    e.tk = 0; e.fl = 0; e.we = 0; e.sel = 0; e.wd = 0; e.z0 = z0_i; e.z1 = z1_i;
    if (valid_i) begin
      if (op_i == 0) begin
        c = (br_type_i == 1) || (br_type_i == 2 && !t_flag_i) || (br_type_i == 3 && t_flag_i);
        e.tk = c; e.fl = c && !dslot_i;
      end else if (op_i == 1) begin
        c = ext_cond_i[ext_sel_i];
        e.tk = c; e.fl = c && !dslot_i;
      end else if (op_i == 2) begin
        e.we = 1; e.sel = cnt_sel_i;
        e.tk = cnt_sel_i ? z1_i : z0_i;
        e.wd = (cnt_sel_i ? r7_i : r6_i) - 16'd1;
        if (cnt_sel_i) e.z1 = (e.wd == 0); else e.z0 = (e.wd == 0);
      end
    end
    t = e.tk ? (longint'(pc_i) + 2 + longint'($signed(disp_i))) : (longint'(pc_i) + 1);
    e.pc = PC_W'(t & 64'h3FFFFF);
    return e;
  endfunction

  task automatic compare(input exp_t e);
    string rt, rf;
    rt = (e.op == 0) ? "R1" : (e.op == 1) ? "R5" : (e.op == 2) ? "R6" : "R9";
    rf = (e.op == 2) ? "R8" : (e.op < 0 || e.op == 3) ? "R9" : "R4";
    chk(taken_o == e.tk, rt, taken_o, e.tk);
    chk(next_pc_o == e.pc, e.tk ? "R2" : "R3", next_pc_o, e.pc);
    chk(flush_o == e.fl, rf, flush_o, e.fl);
    chk(cnt_we_o == e.we, (e.op == 2) ? "R7" : "R9", cnt_we_o, e.we);
    if (e.we) begin
      chk(cnt_sel_o == e.sel, "R7", cnt_sel_o, e.sel);
      chk(cnt_wdata_o == e.wd, "R7", cnt_wdata_o, e.wd);
    end
    chk(z0_o == e.z0 && z1_o == e.z1, (e.op == 2) ? "R7" : "R9", {z1_o, z0_o}, {e.z1, e.z0});
  endtask

  // drive at negedge, compare one clock later at the following negedge
  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] bt, input bit ds,
                      input logic [DISP_W-1:0] d, input logic [PC_W-1:0] pc, input bit t,
                      input logic [3:0] ec, input logic [1:0] es, input bit cs,
                      input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b, input bit z0, input bit z1);
    valid_i = v; op_i = op; br_type_i = bt; dslot_i = ds; disp_i = d; pc_i = pc; t_flag_i = t;
    ext_cond_i = ec; ext_sel_i = es; cnt_sel_i = cs; r6_i = a; r7_i = b; z0_i = z0; z1_i = z1;
    q.push_back(model());
    @(negedge clk_i);
    compare(q.pop_front());
  endtask

  initial begin
    #400000;
    n_fail++; n_run++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step_init();
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(next_pc_o == 0 && !taken_o && !flush_o && !cnt_we_o && !z0_o && !z1_o, "R10",
        {taken_o, flush_o, cnt_we_o, z0_o, z1_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 condition codes, T both ways, no delay slot
    for (int bt = 0; bt < 4; bt++)
      for (int t = 0; t < 2; t++)
        step(1, 0, 2'(bt), 0, 10'h010, 22'h001000, t[0], 0, 0, 0, 5, 5, 0, 0);
    // R4 delay slot set on a taken branch
    step(1, 0, 2'b01, 1, 10'h3F0, 22'h000100, 0, 0, 0, 0, 5, 5, 0, 0);
    // R2 wrap at top and bottom of address space
    step(1, 0, 2'b01, 0, 10'h1FF, 22'h3FFFF0, 0, 0, 0, 0, 5, 5, 0, 0);
    step(1, 0, 2'b01, 0, 10'h200, 22'h000005, 0, 0, 0, 0, 5, 5, 0, 0);
    // R5 each external index, br_type ignored
    for (int s = 0; s < 4; s++) begin
      step(1, 1, 2'b00, 0, 10'h020, 22'h002000, 0, 4'(1 << s), 2'(s), 0, 5, 5, 0, 0);
      step(1, 1, 2'b01, 1, 10'h020, 22'h002000, 1, ~4'(1 << s), 2'(s), 0, 5, 5, 0, 0);
    end
    // R6/R7/R8 loops: stale flag, counter to zero, wrap from zero, both counters
    step(1, 2, 0, 0, 10'h3FC, 22'h003000, 0, 0, 0, 0, 16'd3, 16'd9, 0, 1);
    step(1, 2, 0, 0, 10'h3FC, 22'h003000, 0, 0, 0, 0, 16'd1, 16'd9, 1, 0);
    step(1, 2, 0, 0, 10'h3FC, 22'h003000, 0, 0, 0, 1, 16'd4, 16'd0, 1, 1);
    step(1, 2, 0, 1, 10'h3FC, 22'h003000, 0, 0, 0, 1, 16'd4, 16'd1, 0, 1);
    // R9 idle and reserved op
    step(0, 0, 2'b01, 0, 10'h010, 22'h004000, 1, 4'hF, 0, 0, 1, 1, 1, 0);
    step(1, 3, 2'b01, 0, 10'h010, 22'h004000, 1, 4'hF, 0, 0, 1, 1, 0, 1);
    // back-to-back random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 7) != 0), 2'($urandom), 2'($urandom), 1'($urandom), 10'($urandom),
           22'($urandom), 1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
           16'($urandom_range(0, 3)), 16'($urandom), 1'($urandom), 1'($urandom));
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic step_init();
    valid_i = 0; op_i = 0; br_type_i = 0; dslot_i = 0; disp_i = 0; pc_i = 0; t_flag_i = 0;
    ext_cond_i = 0; ext_sel_i = 0; cnt_sel_i = 0; r6_i = 0; r7_i = 0; z0_i = 0; z1_i = 0;
  endtask
endmodule